// File: doc/BRIEF.md
# Page-Buffered Write Load Controller

This block is a synchronous model of the write front end of a byte-wide nonvolatile memory. The host issues single-cycle byte writes. Each write carries a 17-bit address and 8 bits of data. The controller gathers these writes into a 128-byte page image. The first write sets the page, and later writes to that page may arrive in any order. A page of the wrong page number is refused and raises a sticky error.

A free-running microsecond tick measures how long the host has been idle. When a full inactivity interval passes with no accepted write, the load window closes. The block then goes busy for a timed programming interval. At the end of that interval it hands the whole page to the backing array in a single write. Any byte the host did not load goes out as the erased value FFh. Both intervals are counted in ticks through parameters, so a simulation can shorten them.

Top module: `page_load_ctrl`

## Requirements
- R1: Address bits [16:7] give the page number and bits [6:0] the byte offset. On commit, `arr_page` carries the page number and `arr_data` holds byte k of the page at bits [8k+7:8k].
- R2: Bytes of one page may be loaded at any offsets and in any order. Each one lands at its own offset in the committed image.
- R3: When the block is idle, a write opens a load cycle and captures that write's page number.
- R4: During a load cycle, a write whose page number differs from the captured one changes no byte of the image and does not restart the inactivity count. It sets `page_err`, which stays high until the first write of the next load cycle clears it.
- R5: An accepted write resets the inactivity count. The load window closes on the LOAD_TICKS-th tick that follows with no accepted write, and `busy` is high from the next clock edge. A write in the same cycle as the closing tick is accepted and keeps the window open.
- R6: In the committed image, every offset not loaded in the cycle is FFh. A second write to an offset replaces the first.
- R7: Programming lasts PROG_TICKS ticks. `arr_we` is high for exactly the cycle of the final tick, and `busy` is low from the next edge.
- R8: While `busy` is high, host writes are ignored. They do not change the image, do not set `page_err` and do not start a new cycle.
- R9: After reset, `busy`, `page_err` and `arr_we` are low and the page image is all FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle time-base pulse (one per microsecond) |
| wr_en | input | 1 | Host byte-write strobe |
| wr_addr | input | 17 | Host byte address |
| wr_data | input | 8 | Host write data |
| busy | output | 1 | Internal programming in progress |
| page_err | output | 1 | Sticky page-mismatch flag |
| arr_we | output | 1 | Array page-write strobe |
| arr_page | output | 10 | Page number being committed |
| arr_data | output | 1024 | Full page image being committed |

## Verification
Two collisions are provoked on purpose. In the first, a host write falls in the same cycle as the tick that would close the load window. The write must win, and `busy` must stay low for another full interval. In the second, a host write falls in the cycle of the final programming tick. The write must be dropped, and the next page cycle must begin only on a later write. The bench steps its model to exactly those counts before it issues the write. It then compares `busy`, `page_err`, `arr_we` and the committed image against the model in every cycle.

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W     = 17,
  parameter int OFS_W      = 7,
  parameter int DATA_W     = 8,
  parameter int LOAD_TICKS = 300,
  parameter int PROG_TICKS = 10000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          us_tick,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic                          busy,
  output logic                          page_err,
  output logic                          arr_we,
  output logic [ADDR_W-OFS_W-1:0]       arr_page,
  output logic [(DATA_W<<OFS_W)-1:0]    arr_data
);
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PAGE_W     = ADDR_W - OFS_W;
  localparam int CNT_MAX    = (LOAD_TICKS > PROG_TICKS) ? LOAD_TICKS : PROG_TICKS;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_TICKS - 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_TICKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} mode_t;

  mode_t                                  mode;
  logic [CNT_W-1:0]                       cnt;
  logic [PAGE_W-1:0]                      page;
  logic [PAGE_BYTES-1:0][DATA_W-1:0]      pbuf;
  logic                                   err_q;

  logic [PAGE_W-1:0] wr_page;
  logic [OFS_W-1:0]  wr_ofs;
  logic              hit, miss, open_cyc, close_win, commit;

  assign wr_page   = wr_addr[ADDR_W-1:OFS_W];
  assign wr_ofs    = wr_addr[OFS_W-1:0];
  assign open_cyc  = (mode == S_IDLE) && wr_en;
  assign hit       = (mode == S_LOAD) && wr_en && (wr_page == page);
  assign miss      = (mode == S_LOAD) && wr_en && (wr_page != page);
  assign close_win = (mode == S_LOAD) && !hit && us_tick && (cnt == LOAD_LAST);
  assign commit    = (mode == S_PROG) && us_tick && (cnt == PROG_LAST);

  assign busy     = (mode == S_PROG);
  assign page_err = err_q;
  assign arr_we   = commit;
  assign arr_page = page;
  assign arr_data = pbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= S_IDLE;
      cnt   <= '0;
      page  <= '0;
      pbuf  <= '1;
      err_q <= 1'b0;
    end else begin
      case (mode)
        S_IDLE: if (open_cyc) begin
          mode         <= S_LOAD;
          page         <= wr_page;
          pbuf[wr_ofs] <= wr_data;
          cnt          <= '0;
          err_q        <= 1'b0;
        end
        S_LOAD: begin
          if (miss) err_q <= 1'b1;
          if (hit) begin
            pbuf[wr_ofs] <= wr_data;
            cnt          <= '0;
          end else if (close_win) begin
            mode <= S_PROG;
            cnt  <= '0;
          end else if (us_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PROG: if (commit) begin
          mode <= S_IDLE;
          cnt  <= '0;
          pbuf <= '1;
        end else if (us_tick) begin
          cnt <= cnt + 1'b1;
        end
        default: mode <= S_IDLE;
      endcase
    end
  end

  assert_open_captures_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_IDLE && wr_en) |=> (mode == S_LOAD && page == $past(wr_page) && !page_err));

  assert_page_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_LOAD) |=> (mode != S_LOAD || $stable(page)));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (page_err && !(mode == S_IDLE && wr_en)) |=> page_err);

  assert_miss_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_LOAD && wr_en && wr_page != page) |=> $stable(pbuf));

  assert_timeout_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_LOAD && us_tick && cnt == LOAD_LAST && !(wr_en && wr_page == page)) |=> busy);

  assert_write_keeps_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == S_LOAD && wr_en && wr_page == page) |=> !busy);

  assert_erased_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> (pbuf == '1));

  assert_commit_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy ##1 !busy);

  assert_busy_ignores_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !arr_we) |=> ($stable(pbuf) && $stable(page_err)));
endmodule

// File: tb/page_load_ctrl_test.sv
module page_load_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int LT = 4;
  localparam int PT = 6;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic busy, page_err, arr_we;
  logic [9:0] arr_page;
  logic [1023:0] arr_data;

  page_load_ctrl #(.LOAD_TICKS(LT), .PROG_TICKS(PT)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .page_err(page_err), .arr_we(arr_we),
    .arr_page(arr_page), .arr_data(arr_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, commits = 0;
  string cur = "R9";
  int m_mode = 0, m_cnt = 0, m_page = 0;
  bit m_err = 0;
  logic [7:0] m_buf [128];

  task automatic chk(string what, logic [1023:0] got, logic [1023:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", cur, what, got, exp);
    end
  endtask

  task automatic cyc(bit we, int addr, int data, bit tick);
    logic [1023:0] img;
    bit e_we;
    @(negedge clk);
    wr_en = we; wr_addr = 17'(addr); wr_data = 8'(data); us_tick = tick;
    #1;
    e_we = (m_mode == 2) && tick && (m_cnt == PT - 1);
    chk("busy", {1023'b0, busy}, {1023'b0, m_mode == 2});
    chk("page_err", {1023'b0, page_err}, {1023'b0, m_err});
    chk("arr_we", {1023'b0, arr_we}, {1023'b0, e_we});
    if (e_we) begin
      commits++;
      for (int k = 0; k < 128; k++) img[k*8 +: 8] = m_buf[k];
      chk("arr_page R1", {1014'b0, arr_page}, 1024'(m_page));
      chk("arr_data R6", arr_data, img);
    end
    case (m_mode)
      0: if (we) begin
        m_mode = 1; m_page = addr >> 7; m_buf[addr & 127] = 8'(data); m_cnt = 0; m_err = 0;
      end
      1: begin
        if (we && (addr >> 7) == m_page) begin
          m_buf[addr & 127] = 8'(data); m_cnt = 0;
        end else begin
          if (we) m_err = 1;
          if (tick) begin
            if (m_cnt == LT - 1) begin m_mode = 2; m_cnt = 0; end
            else m_cnt++;
          end
        end
      end
      default: if (tick) begin
        if (m_cnt == PT - 1) begin
          m_mode = 0; m_cnt = 0;
          for (int k = 0; k < 128; k++) m_buf[k] = 8'hFF;
        end else m_cnt++;
      end
    endcase
  endtask

  task automatic idle(int n, int per);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, (i % per) == per - 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && m_mode != 0; i++) cyc(0, 0, 0, i % 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 128; k++) m_buf[k] = 8'hFF;
    repeat (2) @(negedge clk);
    cur = "R9";
    chk("reset busy", {1023'b0, busy}, '0);
    chk("reset page_err", {1023'b0, page_err}, '0);
    chk("reset arr_we", {1023'b0, arr_we}, '0);
    rst_n = 1'b1;

    cur = "R2";
    cyc(1, (10'h1A5 << 7) | 127, 8'h3C, 0);
    cyc(1, (10'h1A5 << 7) | 5, 8'h11, 1);
    idle(3, 2);
    cyc(1, (10'h1A5 << 7) | 2, 8'h22, 0);
    cyc(1, (10'h1A5 << 7) | 0, 8'h00, 1);
    cur = "R3";
    idle(3, 1);
    cur = "R5";
    wait_idle();

    cur = "R4";
    cyc(1, (3 << 7) | 9, 8'h99, 0);
    cyc(1, (4 << 7) | 9, 8'h44, 1);
    cyc(1, (4 << 7) | 1, 8'h45, 1);
    cyc(1, (3 << 7) | 1, 8'h31, 0);
    wait_idle();

    cur = "R6";
    cyc(1, (7 << 7) | 64, 8'hA1, 0);
    cyc(1, (7 << 7) | 64, 8'hB2, 0);
    cyc(1, (7 << 7) | 65, 8'hFF, 1);
    cur = "R5";
    for (int i = 0; i < LT - 1; i++) cyc(0, 0, 0, 1);
    cyc(1, (7 << 7) | 66, 8'h5A, 1);
    idle(LT - 1, 1);
    cur = "R8";
    for (int i = 0; i < 50 && m_mode != 2; i++) cyc(0, 0, 0, 1);
    cyc(1, (7 << 7) | 3, 8'h77, 0);
    cyc(1, (9 << 7) | 3, 8'h78, 1);
    cur = "R7";
    for (int i = 0; i < 50 && !(m_mode == 2 && m_cnt == PT - 1); i++) cyc(0, 0, 0, 1);
    cyc(1, (9 << 7) | 4, 8'h66, 1);
    idle(2, 1);

    cur = "R4";
    cyc(1, (11 << 7) | 8, 8'h08, 0);
    cyc(1, (12 << 7) | 8, 8'h09, 0);
    cyc(1, (13 << 7) | 8, 8'h0A, 1);
    wait_idle();
    cyc(1, (14 << 7) | 1, 8'h01, 0);
    cur = "R1";
    wait_idle();
    idle(4, 1);

    cur = "R7";
    checks++;
    if (commits != 5) begin
      errors++;
      $display("FAIL R7 commit count got %0d exp 5", commits);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule